// File: doc/BRIEF.md
# TLB Replacement Slot Index Counter

This block produces the slot number that the processor's TLB uses when an entry has to be replaced and no particular slot has been requested. The number comes from a down-counter that runs all the time, so which slot gets replaced depends on when the replacement happens. The result is cheap and spreads victims across the TLB. Software sees the counter as a read-only status word, with the index sitting inside one bit field of that word.

One parameter picks between two layouts:

- **High-field layout.** This layout serves a 64-slot TLB. The index runs from 63 down to a fixed floor of 8, and it occupies bits 13:8 of the word.
- **Low-field layout.** This layout serves a 48-slot TLB. The index starts at 47 and its floor is a programmable reserved-slot count, so reserved slots are never chosen for replacement. The index occupies bits 5:0 of the word.

An optional stall input freezes the counter for one cycle at a time.

Top module: `tlb_victim_ctr`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the index equals its upper value: 63 in the high-field layout and 47 in the low-field layout.
- R2: In each clock cycle without stall and without a reserved-count write, an index that is above its floor drops by exactly one.
- R3: In the high-field layout, once the index is 8, the next advancing cycle makes it 63. The index therefore repeats every 56 advancing cycles.
- R4: In the high-field layout, the index is read in bits 13:8 of the status word.
- R5: In the low-field layout with a reserved count of 0, the index counts 47, 46, …, 0 and then returns to 47, a period of 48.
- R6: In the low-field layout with a reserved count W between 1 and 46, the index stops decreasing at W and then returns to 47.
- R7: In the low-field layout, the index is read in bits 5:0 of the status word.
- R8: In the low-field layout, a reserved-count write stores the new count and sets the index to 47 on the next edge. The write takes priority over stall.
- R9: In the low-field layout, a reserved count of 47 or more keeps the index fixed at 47.
- R10: Every status-word bit outside the index field reads as 0.
- R11: When stall is high and no write takes effect, the index keeps its value for that cycle.
- R12: In the high-field layout, writes to the reserved count have no effect on the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Stall: keeps the index for this cycle |
| rsv_we_i | input | 1 | Write strobe for the reserved-slot count |
| rsv_wdata_i | input | IDX_W (6) | New reserved-slot count |
| stat_rdata_o | output | DATA_W (32) | Status word holding the index |

## Verification
The hardest case to reach is the wrap at a floor above zero in the low-field layout. Any write to the reserved count also restarts the index at 47, so the floor cannot be moved while the count is mid-sequence. The bench therefore writes the count first and then lets the index run down to it, which exercises both the floor compare and the wrap. It also writes 45, 46 and 47 to cover the floors that sit right next to the top value. A stall applied in the same cycle as a write checks which of the two wins.

// File: rtl/tlb_victim_pkg.sv
package tlb_victim_pkg;

   typedef enum logic {
      VICT_HI_FIELD64 = 1'b0,
      VICT_LO_FIELD48 = 1'b1
   } vict_layout_e;

   function automatic int unsigned slots_of(vict_layout_e lay);
      return (lay == VICT_HI_FIELD64) ? 64 : 48;
   endfunction

   function automatic int unsigned top_of(vict_layout_e lay);
      return slots_of(lay) - 1;
   endfunction

   function automatic int unsigned fixed_floor_of(vict_layout_e lay);
      return (lay == VICT_HI_FIELD64) ? 8 : 0;
   endfunction

   function automatic int unsigned shift_of(vict_layout_e lay);
      return (lay == VICT_HI_FIELD64) ? 8 : 0;
   endfunction

endpackage

// File: rtl/tlb_victim_floor.sv
module tlb_victim_floor
   import tlb_victim_pkg::*;
#(
   parameter vict_layout_e LAYOUT = VICT_LO_FIELD48,
   parameter int unsigned  IDX_W  = 6,
   localparam int unsigned TOP    = top_of(LAYOUT),
   localparam int unsigned FFLOOR = fixed_floor_of(LAYOUT)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rsv_we_i,
   input  logic [IDX_W-1:0] rsv_wdata_i,
   output logic [IDX_W-1:0] floor_o,
   output logic             reload_o
);

   localparam logic [IDX_W-1:0] TOP_V = IDX_W'(TOP);

   initial begin
      if (TOP >= (1 << IDX_W))
         $error("tlb_victim_floor: IDX_W too small for layout");
   end

   generate
      if (LAYOUT == VICT_LO_FIELD48) begin : g_prog
         logic [IDX_W-1:0] rsv_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       rsv_q <= '0;
            else if (rsv_we_i) rsv_q <= rsv_wdata_i;
         end

         // a reserved count at or past the top pins the floor to the top
         assign floor_o  = (rsv_q >= TOP_V) ? TOP_V : rsv_q;
         assign reload_o = rsv_we_i;

         p_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rsv_we_i |=> rsv_q == $past(rsv_wdata_i));
      end else begin : g_fixed
         logic unused_w;
         assign unused_w = rsv_we_i ^ (^rsv_wdata_i) ^ clk_i;
         assign floor_o  = IDX_W'(FFLOOR);
         assign reload_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/tlb_victim_core.sv
module tlb_victim_core
   import tlb_victim_pkg::*;
#(
   parameter vict_layout_e LAYOUT   = VICT_LO_FIELD48,
   parameter int unsigned  IDX_W    = 6,
   parameter bit           STALL_EN = 1'b1,
   localparam int unsigned TOP      = top_of(LAYOUT)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             hold_i,
   input  logic             reload_i,
   input  logic [IDX_W-1:0] floor_i,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] TOP_V = IDX_W'(TOP);

   logic [IDX_W-1:0] idx_q, idx_d;
   logic             hold_eff;

   generate
      if (STALL_EN) begin : g_stall
         assign hold_eff = hold_i;
      end else begin : g_nostall
         logic unused_h;
         assign unused_h = hold_i;
         assign hold_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      idx_d = idx_q;
      if (reload_i)               idx_d = TOP_V;
      else if (hold_eff)          idx_d = idx_q;
      else if (idx_q <= floor_i)  idx_d = TOP_V;
      else                        idx_d = idx_q - 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) idx_q <= TOP_V;
      else         idx_q <= idx_d;
   end

   assign idx_o = idx_q;

   p_reset_top_r1: assert property (@(posedge clk_i)
      $rose(rst_ni) |-> idx_q == TOP_V);
   p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!reload_i && !hold_eff && idx_q > floor_i) |=> idx_q == $past(idx_q) - 1'b1);
   p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!reload_i && !hold_eff && idx_q <= floor_i) |=> idx_q == TOP_V);
   p_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reload_i |=> idx_q == TOP_V);
   p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_eff && !reload_i) |=> $stable(idx_q));
   p_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx_q <= TOP_V);

endmodule

// File: rtl/tlb_victim_place.sv
module tlb_victim_place #(
   parameter int unsigned IDX_W  = 6,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SHIFT  = 0
) (
   input  logic [IDX_W-1:0]  idx_i,
   output logic [DATA_W-1:0] word_o
);

   initial begin
      if (SHIFT + IDX_W > DATA_W)
         $error("tlb_victim_place: field does not fit the word");
   end

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (b >= SHIFT && b < SHIFT + IDX_W) begin : g_in
            assign word_o[b] = idx_i[b-SHIFT];
         end else begin : g_out
            assign word_o[b] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/tlb_victim_ctr.sv
module tlb_victim_ctr
   import tlb_victim_pkg::*;
#(
   parameter vict_layout_e LAYOUT   = VICT_LO_FIELD48,
   parameter int unsigned  IDX_W    = 6,
   parameter int unsigned  DATA_W   = 32,
   parameter bit           STALL_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              hold_i,
   input  logic              rsv_we_i,
   input  logic [IDX_W-1:0]  rsv_wdata_i,
   output logic [DATA_W-1:0] stat_rdata_o
);

   localparam int unsigned SHIFT = shift_of(LAYOUT);
   localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(((1 << IDX_W) - 1)) << SHIFT;

   logic [IDX_W-1:0] floor_w, idx_w;
   logic             reload_w;

   tlb_victim_floor #(.LAYOUT(LAYOUT), .IDX_W(IDX_W)) u_floor (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rsv_we_i    (rsv_we_i),
      .rsv_wdata_i (rsv_wdata_i),
      .floor_o     (floor_w),
      .reload_o    (reload_w)
   );

   tlb_victim_core #(.LAYOUT(LAYOUT), .IDX_W(IDX_W), .STALL_EN(STALL_EN)) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hold_i   (hold_i),
      .reload_i (reload_w),
      .floor_i  (floor_w),
      .idx_o    (idx_w)
   );

   tlb_victim_place #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SHIFT(SHIFT)) u_place (
      .idx_i  (idx_w),
      .word_o (stat_rdata_o)
   );

   p_outside_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_rdata_o & ~FIELD_MASK) == '0);

endmodule

// File: tb/sim_tlb_victim_ctr.sv
module sim_tlb_victim_ctr;
   import tlb_victim_pkg::*;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic hold0 = 1'b0, we0 = 1'b0, hold1 = 1'b0, we1 = 1'b0;
   logic [5:0] wd0 = '0, wd1 = '0;
   logic [31:0] word0, word1;
   int n_run = 0, n_fail = 0;

   always #2ns clk = ~clk;

   tlb_victim_ctr #(.LAYOUT(VICT_LO_FIELD48)) u0 (
      .clk_i(clk), .rst_ni(rst_ni), .hold_i(hold0), .rsv_we_i(we0),
      .rsv_wdata_i(wd0), .stat_rdata_o(word0));

   tlb_victim_ctr #(.LAYOUT(VICT_HI_FIELD64)) u1 (
      .clk_i(clk), .rst_ni(rst_ni), .hold_i(hold1), .rsv_we_i(we1),
      .rsv_wdata_i(wd1), .stat_rdata_o(word1));

   // {hold, write, write data, expected index after the edge}
   localparam int NV = 30;
   localparam logic [13:0] VEC [NV] = '{
      {1'b0,1'b0,6'd0,6'd46}, {1'b0,1'b0,6'd0,6'd45}, {1'b1,1'b0,6'd0,6'd45},
      {1'b1,1'b0,6'd0,6'd45}, {1'b0,1'b0,6'd0,6'd44}, {1'b0,1'b1,6'd40,6'd47},
      {1'b0,1'b0,6'd0,6'd46}, {1'b0,1'b0,6'd0,6'd45}, {1'b0,1'b0,6'd0,6'd44},
      {1'b0,1'b0,6'd0,6'd43}, {1'b0,1'b0,6'd0,6'd42}, {1'b0,1'b0,6'd0,6'd41},
      {1'b0,1'b0,6'd0,6'd40}, {1'b0,1'b0,6'd0,6'd47}, {1'b0,1'b0,6'd0,6'd46},
      {1'b0,1'b1,6'd50,6'd47},{1'b0,1'b0,6'd0,6'd47}, {1'b1,1'b0,6'd0,6'd47},
      {1'b0,1'b0,6'd0,6'd47}, {1'b1,1'b1,6'd45,6'd47},{1'b0,1'b0,6'd0,6'd46},
      {1'b0,1'b0,6'd0,6'd45}, {1'b0,1'b0,6'd0,6'd47}, {1'b0,1'b1,6'd47,6'd47},
      {1'b0,1'b0,6'd0,6'd47}, {1'b0,1'b1,6'd46,6'd47},{1'b0,1'b0,6'd0,6'd46},
      {1'b0,1'b0,6'd0,6'd47}, {1'b0,1'b1,6'd0,6'd47}, {1'b0,1'b0,6'd0,6'd46}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset;
      rst_ni = 1'b0;
      hold0 = 0; we0 = 0; wd0 = 0; hold1 = 0; we1 = 0; wd1 = 0;
      repeat (3) @(negedge clk);
      chk("R1 low layout in reset", word0, 32'd47);
      chk("R1 high layout in reset", word1, 32'd63 << 8);
      rst_ni = 1'b1;
   endtask

   initial begin
      #(4ns * 200000);
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [5:0] e0, e1;
      do_reset();
      chk("R1 low layout after release", word0, 32'd47);

      // table: R2 R6 R8 R9 R11, word layout R7 R10
      for (int i = 0; i < NV; i++) begin
         hold0 = VEC[i][13];
         we0   = VEC[i][12];
         wd0   = VEC[i][11:6];
         tick();
         chk($sformatf("R2/R6/R8/R9/R11 vector %0d", i), word0, {26'd0, VEC[i][5:0]});
      end
      hold0 = 0; we0 = 0; wd0 = 0;

      // directed: full periods of both layouts from reset
      do_reset();
      chk("R1 high layout after release", word1, 32'd63 << 8);
      e0 = 6'd47;
      e1 = 6'd63;
      for (int k = 0; k < 130; k++) begin
         hold1 = (k == 20 || k == 21);
         we1   = (k == 30 || k == 70);
         wd1   = 6'd20;
         tick();
         e0 = (e0 == 6'd0) ? 6'd47 : e0 - 6'd1;
         if (!(k == 20 || k == 21)) e1 = (e1 == 6'd8) ? 6'd63 : e1 - 6'd1;
         chk($sformatf("R5 R7 R10 low step %0d", k), word0, {26'd0, e0});
         chk($sformatf("R3 R4 R10 R11 R12 high step %0d", k), word1, {18'd0, e1, 8'd0});
      end
      hold1 = 0; we1 = 0;

      // corner: reserved count 63 pins the index at 47
      we0 = 1; wd0 = 6'd63; tick(); we0 = 0;
      for (int k = 0; k < 5; k++) begin
         tick();
         chk("R9 count 63 holds", word0, 32'd47);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule